// File: doc/BRIEF.md
# Six-Bit NOR Processor Core

This block is a small multi-cycle processor core for a minimal instruction set built around a single logic operation, NOR. Data words are 6 bits wide and addresses are 12 bits, formed from two data words. The core holds three general registers (A, B, C) and a 12-bit program counter. It steps through each instruction in several states: it fetches the instruction word, resolves the two operands, and then executes. Either operand can be a register or an inline immediate word taken from the next memory location, so an instruction is one, two or three words long.

The core drives one synchronous memory port. The address is presented in one cycle and the read word is expected on `mem_rdata` in the next cycle. A store asserts `mem_we` for a single cycle. The program counter and a halted flag are visible as outputs, and an illegal-instruction pulse reports the reserved encodings. Programs are loaded into the attached memory while the core is held in reset. Releasing reset starts execution at address zero.

Top module: `nor6_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core clears A, B, C and the program counter to zero, and clears `halted` and `illegal_op`. No store is issued during reset.
- R2: An instruction word carries its operation in bits 5:4, its first operand selector in bits 3:2 and its second operand selector in bits 1:0. The operation codes are 00 NOR, 01 set program counter, 10 load and 11 store.
- R3: The selector codes are 00 A, 01 B, 10 C and 11 immediate. An immediate operand advances the program counter and takes the word at the new address. The first operand is resolved before the second, and the counter advances once more after both.
- R4: NOR writes the bitwise complement of (operand one OR operand two) into the register named by the first selector.
- R5: Set-PC loads operand one into counter bits 11:6 and operand two into bits 5:0. Execution continues at that address.
- R6: Load copies the memory word at address {operand one, operand two} into C. Store writes C to that address, with `mem_we` high for exactly one cycle.
- R7: Word 001100 is a no-operation. It only advances the program counter by one.
- R8: Words 001101 and 001110 behave as one-word no-operations. Each raises `illegal_op` for exactly one cycle.
- R9: When the word at the current program counter is 001111, the core raises `halted` without executing that word. The program counter then stays at that address and no further store is issued until reset.
- R10: The program counter advances as one 12-bit value and wraps from 0xFFF to 0x000. This also applies when an immediate is fetched across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Memory address for fetch, load or store |
| mem_rdata | input | 6 | Read word, valid one cycle after its address |
| mem_wdata | output | 6 | Store data (register C) |
| mem_we | output | 1 | Store strobe, one cycle per store |
| pc | output | 12 | Current program counter |
| halted | output | 1 | High once a halt word is reached |
| illegal_op | output | 1 | One-cycle pulse on a reserved word |

## Verification
Registers are not visible at the ports, so a corrupted register or operand latch shows up only when a later store carries it out. The store's address or data then mismatches within that same instruction sequence, a few tens of cycles after the fault. A program counter that steps wrongly, or an immediate consumed from the wrong word, misaligns every later fetch. The error then surfaces as a wrong store or as a halt at an unexpected address, so each test program ends by comparing the resting program counter. A decode slip on the special words shows immediately: a wrong count of `illegal_op` cycles, or `halted` rising early or never.

// File: rtl/nor6_pkg.sv
// Shared types for the six-bit NOR core: operation and selector codes,
// controller states and the decoded instruction record.
// Assumes a 6-bit instruction word with three 2-bit fields.
package nor6_pkg;

    localparam int WORD_BITS = 6;

    typedef enum logic [1:0] {
        OP_NOR = 2'b00,
        OP_JMP = 2'b01,
        OP_LD  = 2'b10,
        OP_ST  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SEL_A   = 2'b00,
        SEL_B   = 2'b01,
        SEL_C   = 2'b10,
        SEL_IMM = 2'b11
    } sel_e;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OP1_REQ,
        ST_OP1_CAP,
        ST_OP2_SEL,
        ST_OP2_REQ,
        ST_OP2_CAP,
        ST_EXEC,
        ST_LD_WAIT,
        ST_HALT
    } state_e;

    // Special words live in the "NOR into immediate" slot.
    localparam logic [WORD_BITS-1:0] W_NOP  = 6'b001100;
    localparam logic [WORD_BITS-1:0] W_HLT  = 6'b001111;
    localparam logic [3:0]           SPECIAL_HI = 4'b0011;

    typedef struct packed {
        op_e  op;
        sel_e src1;
        sel_e src2;
        logic is_nop;
        logic is_rsv;
        logic is_hlt;
    } dec_t;

endpackage

// File: rtl/nor6_decode.sv
// Combinational instruction decoder. Splits a word into its operation and
// two operand selectors, and flags the four special words.
// Assumes WORD_W is 6; the field positions are fixed by the instruction set.
module nor6_decode
    import nor6_pkg::*;
#(
    parameter int WORD_W = nor6_pkg::WORD_BITS
) (
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);

    logic special;

    // Field split and special-word classification.
    always_comb begin
        special    = (word[5:2] == SPECIAL_HI);
        dec.op     = op_e'(word[5:4]);
        dec.src1   = sel_e'(word[3:2]);
        dec.src2   = sel_e'(word[1:0]);
        dec.is_nop = (word == W_NOP);
        dec.is_hlt = (word == W_HLT);
        dec.is_rsv = special && (word != W_NOP) && (word != W_HLT);
    end

endmodule

// File: rtl/nor6_pc.sv
// Program counter: a single ADDR_W-bit register that either loads a full
// target or steps by one, wrapping at the top of the address space.
// Assumes load and step are never needed in different directions at once;
// load wins.
module nor6_pc #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc_q
);

    // Counter update with reset to address zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (load) begin
            pc_q <= target;
        end else if (step) begin
            pc_q <= pc_q + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/nor6_regfile.sv
// Three general registers with one write port and one selector-driven read
// port. Register C is also brought out for the store path.
// Assumes the immediate selector never addresses a register; reads of it
// return zero and writes to it are dropped.
module nor6_regfile
    import nor6_pkg::*;
#(
    parameter int WORD_W = nor6_pkg::WORD_BITS,
    parameter int NREGS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  sel_e              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  sel_e              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] c_val
);

    logic [WORD_W-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        // One register slot, written when the selector names it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (int'(wr_sel) == g)) begin
                regs[g] <= wr_data;
            end
        end
    end

    // Operand read mux.
    always_comb begin
        case (rd_sel)
            SEL_A:   rd_data = regs[0];
            SEL_B:   rd_data = regs[1];
            SEL_C:   rd_data = regs[2];
            default: rd_data = '0;
        endcase
    end

    assign c_val = regs[2];

endmodule

// File: rtl/nor6_ctrl.sv
// Multi-cycle controller. Each memory word takes a request state followed
// by a capture state, because read data arrives one cycle after the address.
// It sequences fetch, operand resolution (first operand before second),
// execution and the halt stop.
// Assumes the decoder is fed from dec_word and its result returned on dec.
module nor6_ctrl
    import nor6_pkg::*;
#(
    parameter int WORD_W = nor6_pkg::WORD_BITS,
    parameter int ADDR_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] pc_q,
    input  dec_t              dec,
    input  logic [WORD_W-1:0] rd_data,
    input  logic [WORD_W-1:0] c_val,
    output logic [WORD_W-1:0] dec_word,
    output sel_e              rd_sel,
    output logic              rf_we,
    output sel_e              rf_sel,
    output logic [WORD_W-1:0] rf_wdata,
    output logic              pc_step,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_target,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              halted,
    output logic              illegal_op
);

    state_e            state;
    logic [WORD_W-1:0] ir;
    logic [WORD_W-1:0] opnd1;
    logic [WORD_W-1:0] opnd2;
    logic              illegal_q;
    logic [ADDR_W-1:0] data_addr;

    assign data_addr = {opnd1, opnd2};
    assign dec_word  = (state == ST_DECODE) ? mem_rdata : ir;

    // Register read selector: first operand while decoding, second after.
    always_comb begin
        rd_sel = (state == ST_OP2_SEL) ? dec.src2 : dec.src1;
    end

    // Program counter control.
    always_comb begin
        pc_step   = 1'b0;
        pc_load   = 1'b0;
        pc_target = data_addr;
        unique case (state)
            ST_DECODE:  pc_step = !dec.is_hlt &&
                                  (dec.is_nop || dec.is_rsv || dec.src1 == SEL_IMM);
            ST_OP2_SEL: pc_step = (dec.src2 == SEL_IMM);
            ST_EXEC: begin
                pc_step = 1'b1;
                pc_load = (dec.op == OP_JMP);
            end
            default: ;
        endcase
    end

    // Register write port: NOR result or loaded word into C.
    always_comb begin
        rf_we    = 1'b0;
        rf_sel   = dec.src1;
        rf_wdata = ~(opnd1 | opnd2);
        if (state == ST_EXEC && dec.op == OP_NOR) begin
            rf_we = 1'b1;
        end else if (state == ST_LD_WAIT) begin
            rf_we    = 1'b1;
            rf_sel   = SEL_C;
            rf_wdata = mem_rdata;
        end
    end

    // Memory port: program counter except for data access in execute.
    always_comb begin
        mem_addr  = pc_q;
        mem_we    = 1'b0;
        mem_wdata = c_val;
        if (state == ST_EXEC && (dec.op == OP_LD || dec.op == OP_ST)) begin
            mem_addr = data_addr;
            mem_we   = (dec.op == OP_ST);
        end
    end

    // State sequencing and operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_FETCH;
            ir        <= '0;
            opnd1     <= '0;
            opnd2     <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= 1'b0;
            unique case (state)
                ST_FETCH: state <= ST_DECODE;
                ST_DECODE: begin
                    ir <= mem_rdata;
                    if (dec.is_hlt) begin
                        state <= ST_HALT;
                    end else if (dec.is_nop || dec.is_rsv) begin
                        illegal_q <= dec.is_rsv;
                        state     <= ST_FETCH;
                    end else if (dec.src1 == SEL_IMM) begin
                        state <= ST_OP1_REQ;
                    end else begin
                        opnd1 <= rd_data;
                        state <= ST_OP2_SEL;
                    end
                end
                ST_OP1_REQ: state <= ST_OP1_CAP;
                ST_OP1_CAP: begin
                    opnd1 <= mem_rdata;
                    state <= ST_OP2_SEL;
                end
                ST_OP2_SEL: begin
                    if (dec.src2 == SEL_IMM) begin
                        state <= ST_OP2_REQ;
                    end else begin
                        opnd2 <= rd_data;
                        state <= ST_EXEC;
                    end
                end
                ST_OP2_REQ: state <= ST_OP2_CAP;
                ST_OP2_CAP: begin
                    opnd2 <= mem_rdata;
                    state <= ST_EXEC;
                end
                ST_EXEC:    state <= (dec.op == OP_LD) ? ST_LD_WAIT : ST_FETCH;
                ST_LD_WAIT: state <= ST_FETCH;
                ST_HALT:    state <= ST_HALT;
                default:    state <= ST_FETCH;
            endcase
        end
    end

    assign halted     = (state == ST_HALT);
    assign illegal_op = illegal_q;

endmodule

// File: rtl/nor6_core.sv
// Top of the six-bit NOR core: wires controller, decoder, register file and
// program counter to one synchronous memory port.
// Assumes memory returns read data one cycle after the address is driven.
module nor6_core
    import nor6_pkg::*;
#(
    parameter int WORD_W = nor6_pkg::WORD_BITS,
    localparam int ADDR_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] pc,
    output logic              halted,
    output logic              illegal_op
);

    dec_t              dec;
    logic [WORD_W-1:0] dec_word;
    sel_e              rd_sel;
    logic [WORD_W-1:0] rd_data;
    logic [WORD_W-1:0] c_val;
    logic              rf_we;
    sel_e              rf_sel;
    logic [WORD_W-1:0] rf_wdata;
    logic              pc_step;
    logic              pc_load;
    logic [ADDR_W-1:0] pc_target;
    logic [ADDR_W-1:0] pc_q;

    nor6_decode #(.WORD_W(WORD_W)) u_dec (
        .word (dec_word),
        .dec  (dec)
    );

    nor6_regfile #(.WORD_W(WORD_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_we),
        .wr_sel  (rf_sel),
        .wr_data (rf_wdata),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .c_val   (c_val)
    );

    nor6_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (pc_step),
        .load   (pc_load),
        .target (pc_target),
        .pc_q   (pc_q)
    );

    nor6_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_rdata  (mem_rdata),
        .pc_q       (pc_q),
        .dec        (dec),
        .rd_data    (rd_data),
        .c_val      (c_val),
        .dec_word   (dec_word),
        .rd_sel     (rd_sel),
        .rf_we      (rf_we),
        .rf_sel     (rf_sel),
        .rf_wdata   (rf_wdata),
        .pc_step    (pc_step),
        .pc_load    (pc_load),
        .pc_target  (pc_target),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .halted     (halted),
        .illegal_op (illegal_op)
    );

    assign pc = pc_q;

endmodule

// File: rtl/nor6_core_chk.sv
// Port-level protocol checks for nor6_core, attached by bind.
// Assumes a synchronous active-low reset.
module nor6_core_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pc,
    input logic              halted,
    input logic              illegal_op,
    input logic              mem_we
);

    // R1: a reset edge leaves the counter at zero and the flags low.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && !halted && !illegal_op && !mem_we));

    // R9: once halted, the core stays halted on the same address.
    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc)));

    // R9: no store leaves a halted core.
    assert_no_store_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R8: the illegal indication lasts a single cycle.
    assert_illegal_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |=> !illegal_op);

    // R8: a reserved word advances the counter by exactly one.
    assert_illegal_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal_op) |-> (pc == $past(pc) + ADDR_W'(1)));

    // R6: a store strobe is one cycle wide.
    assert_store_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

endmodule

bind nor6_core nor6_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc         (pc),
    .halted     (halted),
    .illegal_op (illegal_op),
    .mem_we     (mem_we)
);

// File: tb/tb_nor6_core.sv
// Scoreboard bench: each program pushes its expected stores into a queue,
// and a monitor pops and compares them as the core writes memory.
module tb_nor6_core;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_DEPTH  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [5:0]  mem_rdata;
    logic [5:0]  mem_wdata;
    logic        mem_we;
    logic [11:0] pc;
    logic        halted;
    logic        illegal_op;

    logic [5:0]  mem [MEM_DEPTH];

    int checks = 0;
    int fails  = 0;
    int ill_cnt = 0;
    bit done = 0;

    logic [11:0] q_addr [$];
    logic [5:0]  q_data [$];
    string       q_tag  [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    nor6_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .pc         (pc),
        .halted     (halted),
        .illegal_op (illegal_op)
    );

    // Synchronous memory model, one cycle read latency.
    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard.
    task automatic push_exp(input logic [11:0] a, input logic [5:0] d, input string tag);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare each store with the head of the queue; count pulses.
    always @(negedge clk) begin
        if (rst_n && illegal_op) ill_cnt++;
        if (rst_n && mem_we) begin
            if (q_addr.size() == 0) begin
                chk(1'b0, "R9", "unexpected store addr", int'(mem_addr), 0);
            end else begin
                automatic logic [11:0] ea = q_addr.pop_front();
                automatic logic [5:0]  ed = q_data.pop_front();
                automatic string       et = q_tag.pop_front();
                chk(mem_addr == ea, et, "store address", int'(mem_addr), int'(ea));
                chk(mem_wdata == ed, et, "store data", int'(mem_wdata), int'(ed));
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < MEM_DEPTH; i++) mem[i] = 6'b000000;
    endtask

    task automatic load_prog(input logic [11:0] base, input logic [5:0] w []);
        for (int i = 0; i < w.size(); i++) mem[12'(int'(base) + i)] = w[i];
    endtask

    // Release reset, wait for halt, then check resting state.
    task automatic run_prog(input logic [11:0] exp_pc, input int exp_ill, input string tag);
        int n;
        logic [11:0] held;
        ill_cnt = 0;
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(halted == 1'b1, "R9", {tag, " halted raised"}, int'(halted), 1);
        chk(pc == exp_pc, "R9", {tag, " pc at halt word"}, int'(pc), int'(exp_pc));
        chk(ill_cnt == exp_ill, "R8", {tag, " illegal cycles"}, ill_cnt, exp_ill);
        chk(q_addr.size() == 0, "R6", {tag, " stores outstanding"}, q_addr.size(), 0);
        held = pc;
        repeat (4) @(negedge clk);
        chk(halted && pc == held, "R9", {tag, " halt holds"}, int'(pc), int'(held));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_reset(input string tag);
        chk(pc == 12'h000, "R1", {tag, " pc"}, int'(pc), 0);
        chk(!halted, "R1", {tag, " halted"}, int'(halted), 0);
        chk(!illegal_op, "R1", {tag, " illegal"}, int'(illegal_op), 0);
        chk(!mem_we, "R1", {tag, " mem_we"}, int'(mem_we), 0);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected halt");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset("initial reset");

        // R2 R3 R4: zero A, load complement, invert, move ~A into C, store.
        clear_mem();
        load_prog(12'h000, '{6'b000011, 6'b111111, 6'b000011, 6'b010101,
                             6'b000000, 6'b001011, 6'b111111, 6'b001000,
                             6'b111111, 6'b000010, 6'b000001, 6'b001111});
        push_exp(12'h081, 6'b101010, "R4");
        run_prog(12'd11, 0, "nor program");

        // R1: reset after a halted run clears counter and flags.
        check_reset("reset after halt");

        // R6 R7 R8 R3: load, reserved words, NOP, register-addressed store.
        clear_mem();
        mem[12'h100] = 6'b110011;
        load_prog(12'h000, '{6'b101111, 6'b000100, 6'b000000, 6'b001101,
                             6'b001100, 6'b001110, 6'b000111, 6'b111111,
                             6'b000110, 6'b110110, 6'b001111});
        push_exp(12'h333, 6'b110011, "R6");
        run_prog(12'd10, 2, "load program");

        // R5 R10 R1: jump to 0xFFE, immediate fetched across the wrap; C starts at zero.
        clear_mem();
        load_prog(12'h000, '{6'b011111, 6'b111111, 6'b111110, 6'b000101, 6'b001111});
        mem[12'hFFE] = 6'b001100;
        mem[12'hFFF] = 6'b001011;
        push_exp(12'hF85, 6'b100000, "R10");
        run_prog(12'd4, 0, "wrap program");

        // R5 R3: set-PC from registers A and B skips halt words.
        clear_mem();
        load_prog(12'h000, '{6'b000011, 6'b111111, 6'b000111, 6'b110111,
                             6'b010001, 6'b001111, 6'b001111, 6'b001111,
                             6'b001011, 6'b111111, 6'b001001, 6'b110000,
                             6'b001111});
        push_exp(12'h000, 6'b110111, "R5");
        run_prog(12'd12, 0, "jump program");

        // R9: halt as the first word is never executed and issues no store.
        clear_mem();
        mem[0] = 6'b001111;
        run_prog(12'd0, 0, "halt first");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule